// File: doc/BRIEF.md
# Adjustable SOF Frame Timer

This block runs on the 12 MHz bit-rate clock of a USB host and marks frame boundaries. It counts the cycles of one frame. At the end of each frame it raises a single-cycle start-of-frame strobe and advances an 11-bit frame number, which wraps around. The length of a frame is 12,000 cycles plus a signed trim. Host firmware sets the trim to make up for error in the reference clock.

The trim is read only at a frame boundary. A new trim value therefore never stretches or shortens the frame already being counted; it sets the length of the frame that starts next. While host operation is switched off, the counter and the frame number stay at zero and no strobe appears. The trim is read continuously during that time, so the first frame after enabling uses the value present in the last disabled cycle.

Top module: `sof_frame_timer`

## Requirements
- R1: After a synchronous active-high reset, `sof_pulse` is 0 and `frame_num` is 0. The first frame after reset is released has the nominal length, whatever the trim input holds.
- R2: The length of a frame, measured from one `sof_pulse` to the next, is `NOM_PERIOD` plus the signed trim. The default `NOM_PERIOD` is 12,000, so the length ranges from 11,872 to 12,127 cycles, and a trim of 0 gives exactly 12,000.
- R3: The trim in effect for a frame is the value on `trim_in` at the clock edge that raises `sof_pulse` at the start of that frame. A change at any later cycle of the frame does not alter that frame's length.
- R4: `sof_pulse` is high for exactly one cycle per frame.
- R5: `frame_num` increases by one in the same cycle that `sof_pulse` is high, and holds its value in every other enabled cycle.
- R6: `frame_num` is 11 bits wide and wraps from 2047 to 0.
- R7: While `host_en` is 0, `sof_pulse` stays 0 and `frame_num` stays 0. After `host_en` rises, the first strobe comes after exactly one frame length, using the trim value present in the last disabled cycle.
- R8: `trim_in` is two's complement with bit 7 as the sign: 8'h7F is +127, 8'h80 is -128, 8'hFF is -1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 12 MHz frame clock |
| rst | input | 1 | Synchronous reset, active high |
| host_en | input | 1 | Host operation enable; 0 holds the timer idle |
| trim_in | input | TRIM_W (8) | Signed frame-length trim in clock periods |
| sof_pulse | output | 1 | One-cycle strobe at each frame boundary |
| frame_num | output | FNUM_W (11) | Current frame number |

## Verification
Two events can fall in the same cycle: a trim update and the frame boundary at which the trim is sampled. The bench changes `trim_in` one cycle before the boundary edge and checks that the next frame takes the new length. It then changes the trim in the very cycle in which `sof_pulse` is high and checks that this value waits a full frame before it takes effect. Disabling host operation is also made to coincide with a running count, and the bench checks that the strobe and the frame number stay at zero.

// File: rtl/sof_timer_pkg.sv
package sof_timer_pkg;

  // Sign-extend the low `w` bits of `raw` to a signed integer.
  function automatic int trim_offset(input logic [15:0] raw, input int unsigned w);
    int v;
    v = int'(raw & 16'((32'd1 << w) - 1));
    if (raw[w-1])
      v = v - (32'sd1 <<< w);
    return v;
  endfunction

endpackage

// File: rtl/sof_period_latch.sv
module sof_period_latch #(
  parameter int unsigned NOM_PERIOD = 12000,
  parameter int unsigned TRIM_W     = 8,
  parameter int unsigned CNT_W      = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [TRIM_W-1:0] trim,
  output logic [CNT_W-1:0]  period_q
);
  import sof_timer_pkg::*;

  logic [CNT_W-1:0] period_d;

  always_comb begin
    period_d = CNT_W'(int'(NOM_PERIOD) + trim_offset(16'(trim), TRIM_W));
  end

  // Period is captured only at a boundary (or continuously while idle).
  always_ff @(posedge clk) begin
    if (rst)
      period_q <= CNT_W'(NOM_PERIOD);
    else if (load)
      period_q <= period_d;
  end
endmodule

// File: rtl/sof_cycle_counter.sv
module sof_cycle_counter #(
  parameter int unsigned CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [CNT_W-1:0] period,
  output logic             wrap
);
  logic [CNT_W-1:0] cnt_q;

  assign wrap = run && (cnt_q == period - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst || !run)
      cnt_q <= '0;
    else if (wrap)
      cnt_q <= '0;
    else
      cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/sof_frame_number.sv
module sof_frame_number #(
  parameter int unsigned FNUM_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              wrap,
  output logic              sof_q,
  output logic [FNUM_W-1:0] fnum_q
);
  always_ff @(posedge clk) begin
    if (rst || !run) begin
      sof_q  <= 1'b0;
      fnum_q <= '0;
    end else begin
      sof_q <= wrap;
      if (wrap)
        fnum_q <= fnum_q + FNUM_W'(1);
    end
  end
endmodule

// File: rtl/sof_frame_timer.sv
module sof_frame_timer #(
  parameter int unsigned NOM_PERIOD = 12000,
  parameter int unsigned TRIM_W     = 8,
  parameter int unsigned FNUM_W     = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_en,
  input  logic [TRIM_W-1:0] trim_in,
  output logic              sof_pulse,
  output logic [FNUM_W-1:0] frame_num
);
  localparam int unsigned MAX_PERIOD = NOM_PERIOD + (2 ** (TRIM_W - 1)) - 1;
  localparam int unsigned CNT_W      = $clog2(MAX_PERIOD + 1);

  logic [CNT_W-1:0] period_q;
  logic             wrap;
  logic             load_period;

  assign load_period = !host_en || wrap;

  sof_period_latch #(
    .NOM_PERIOD(NOM_PERIOD),
    .TRIM_W    (TRIM_W),
    .CNT_W     (CNT_W)
  ) u_latch (
    .clk     (clk),
    .rst     (rst),
    .load    (load_period),
    .trim    (trim_in),
    .period_q(period_q)
  );

  sof_cycle_counter #(
    .CNT_W(CNT_W)
  ) u_count (
    .clk   (clk),
    .rst   (rst),
    .run   (host_en),
    .period(period_q),
    .wrap  (wrap)
  );

  sof_frame_number #(
    .FNUM_W(FNUM_W)
  ) u_fnum (
    .clk   (clk),
    .rst   (rst),
    .run   (host_en),
    .wrap  (wrap),
    .sof_q (sof_pulse),
    .fnum_q(frame_num)
  );
endmodule

// File: rtl/sof_frame_timer_chk.sv
module sof_frame_timer_chk #(
  parameter int unsigned NOM_PERIOD = 12000,
  parameter int unsigned TRIM_W     = 8,
  parameter int unsigned FNUM_W     = 11
) (
  input logic              clk,
  input logic              rst,
  input logic              host_en,
  input logic              sof_pulse,
  input logic [FNUM_W-1:0] frame_num
);
  localparam int unsigned MAXP = NOM_PERIOD + (2 ** (TRIM_W - 1)) - 1;

  logic [31:0] gap_q;

  always_ff @(posedge clk) begin
    if (rst || !host_en || sof_pulse)
      gap_q <= '0;
    else
      gap_q <= gap_q + 32'd1;
  end

  a_r4_single_cycle: assert property (@(posedge clk) disable iff (rst)
    sof_pulse |=> !sof_pulse);

  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !host_en |=> (!sof_pulse && frame_num == '0));

  a_r5_step_on_sof: assert property (@(posedge clk) disable iff (rst)
    sof_pulse |-> frame_num == $past(frame_num) + FNUM_W'(1));

  a_r5_hold_between: assert property (@(posedge clk) disable iff (rst)
    (!sof_pulse && $past(host_en) && !$past(rst)) |-> $stable(frame_num));

  a_r2_length_bound: assert property (@(posedge clk) disable iff (rst)
    gap_q <= MAXP);
endmodule

bind sof_frame_timer sof_frame_timer_chk #(
  .NOM_PERIOD(NOM_PERIOD),
  .TRIM_W    (TRIM_W),
  .FNUM_W    (FNUM_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .host_en  (host_en),
  .sof_pulse(sof_pulse),
  .frame_num(frame_num)
);

// File: tb/sof_frame_timer_tb.sv
`timescale 1ns/1ps
module sof_frame_timer_tb;
  localparam int NOM = 140;
  localparam int VEC_N = 6;
  // trim code (R8 encoding) and expected frame length NOM + signed trim
  localparam logic [7:0] V_TRIM [VEC_N] = '{8'h00, 8'h7F, 8'h80, 8'hFF, 8'h01, 8'h9C};
  localparam int         V_LEN  [VEC_N] = '{140,   267,   12,    139,   141,   40};

  logic        clk = 1'b0;
  logic        rst;
  logic        host_en;
  logic [7:0]  trim;
  logic        sof_pulse;
  logic [10:0] frame_num;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  sof_frame_timer #(.NOM_PERIOD(NOM), .TRIM_W(8), .FNUM_W(11)) u_dut (
    .clk(clk), .rst(rst), .host_en(host_en), .trim_in(trim),
    .sof_pulse(sof_pulse), .frame_num(frame_num)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // counts negedges until sof_pulse is seen high
  task automatic gap(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!sof_pulse);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n;
    int prev;
    int bad;
    int badlen;
    rst = 1'b1; host_en = 1'b0; trim = 8'h00;
    repeat (3) @(negedge clk);
    check(sof_pulse == 1'b0, "R1 reset sof", sof_pulse, 0);
    check(frame_num == 11'd0, "R1 reset frame_num", frame_num, 0);
    rst = 1'b0; host_en = 1'b1;
    gap(n);
    check(n == NOM, "R2 first frame nominal", n, NOM);
    check(frame_num == 11'd1, "R5 first increment", frame_num, 1);

    // vector table: trim applied for the frame after the next boundary
    for (int i = 0; i < VEC_N; i++) begin
      trim = V_TRIM[i];
      gap(n);
      prev = frame_num;
      gap(n);
      check(n == V_LEN[i], "R2 R8 frame length", n, V_LEN[i]);
      check(frame_num == ((prev + 1) % 2048), "R5 step", frame_num, (prev + 1) % 2048);
    end

    // current frame is 40 cycles; change trim while it runs (R3)
    trim = 8'h00;
    @(negedge clk);
    check(sof_pulse == 1'b0, "R4 pulse width", sof_pulse, 0);
    gap(n);
    check(n + 1 == 40, "R3 change at sof cycle deferred", n + 1, 40);
    repeat (5) @(negedge clk);
    trim = 8'h7F;
    gap(n);
    check(n + 5 == NOM, "R3 mid-frame change ignored", n + 5, NOM);
    gap(n);
    check(n == 267, "R3 change used next frame", n, 267);

    // boundary coincidence: change one cycle before the boundary edge
    trim = 8'h00;
    gap(n);
    check(n == 267, "R3 running frame kept", n, 267);
    repeat (NOM - 1) @(negedge clk);
    trim = 8'h9C;
    @(negedge clk);
    check(sof_pulse == 1'b1, "R2 boundary timing", sof_pulse, 1);
    trim = 8'h01;
    gap(n);
    check(n == 40, "R3 trim at boundary edge sampled", n, 40);
    gap(n);
    check(n == 141, "R3 trim in sof cycle waits a frame", n, 141);

    // reset while running
    repeat (7) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(sof_pulse == 1'b0 && frame_num == 11'd0, "R1 reset mid-run", frame_num, 0);
    rst = 1'b0;
    gap(n);
    check(n == NOM, "R1 nominal after reset", n, NOM);
    gap(n);
    check(n == 141, "R1 trim resumes after reset", n, 141);

    // idle
    host_en = 1'b0;
    bad = 0;
    repeat (300) begin
      @(negedge clk);
      if (sof_pulse || frame_num != 11'd0) bad++;
    end
    check(bad == 0, "R7 idle quiet", bad, 0);
    trim = 8'hFF;
    @(negedge clk);
    host_en = 1'b1;
    gap(n);
    check(n == 139, "R7 first frame after enable", n, 139);
    check(frame_num == 11'd1, "R7 frame_num restarts", frame_num, 1);

    // wrap of the frame number with shortest frames
    host_en = 1'b0;
    trim = 8'h80;
    @(negedge clk);
    host_en = 1'b1;
    bad = 0;
    badlen = 0;
    for (int i = 1; i <= 2048; i++) begin
      gap(n);
      if (frame_num != 11'(i % 2048)) bad++;
      if (n != 12) badlen++;
      if (i == 2047) check(frame_num == 11'd2047, "R6 top value", frame_num, 2047);
    end
    check(frame_num == 11'd0, "R6 wrap to zero", frame_num, 0);
    check(bad == 0, "R5 count sequence", bad, 0);
    check(badlen == 0, "R2 minimum length", badlen, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule